// File: doc/BRIEF.md
# Programmable Step Trigger Sequencer

This block decides when an embedded logic analyzer should start capturing. Its input is a small vector of match bits, one per value comparator. It steps through a programmed list of up to sixteen conditions. Each step holds a truth table indexed by the match vector, so a step can test any Boolean function of the bits. Each step also holds a required occurrence count and two mode flags. The link flag selects whether the step may be satisfied at any later sample or must begin on the sample right after the previous step finished. The count flag selects whether the occurrences may be spread out or must be back to back. When the final step completes, the block emits a one-cycle trigger pulse. It then holds until it is disarmed.

Software programs the steps through a write port while the `armed` input is low, and sets the index of the last active step. It then raises `armed`. Work happens only on cycles where `sampleEn` is high. A broken must-be-next or back-to-back rule sends the whole sequence back to the first step.

Top module: `trig_seq`

## Requirements
- R1: After reset, and on every cycle following one where `armed` is low, `stepIdx` is 0, `trigger` is 0 and the occurrence counter is cleared.
- R2: A cycle with `sampleEn` low leaves `stepIdx` unchanged and gives no trigger, whatever `matchBits` holds.
- R3: A step's condition is true when bit number `matchBits` (read as an unsigned index) of that step's `cfgTable` is 1.
- R4: A step with `cfgNext`=0 may be satisfied any number of samples after the previous step completed.
- R5: A step with `cfgNext`=1 (step index above 0) must see its condition true on the first sample after the previous step completed. Otherwise the engine returns to step 0.
- R6: A step with `cfgConsec`=0 completes on the sample where its condition has been true `cfgCount` times, with any number of false samples in between. A count of 0 or 1 means a single occurrence.
- R7: A step with `cfgConsec`=1 completes after `cfgCount` back-to-back true samples. A false sample after at least one hit returns the engine to step 0.
- R8: With `cfgNext`=1 and `cfgConsec`=1 together, the first of the back-to-back hits must fall on the sample directly after the previous step completed.
- R9: One sample advances the engine by at most one step. A sample that breaks a rule sends the engine to step 0 without being tested against step 0.
- R10: `trigger` is high for exactly the one cycle after the sample that completes step `lastStep`. After that, samples are ignored and `stepIdx` holds until `armed` drops.
- R11: The number of active steps is `lastStep`+1, anywhere from 1 to 16.
- R12: A configuration write (`cfgWe` high) takes effect only while `armed` is low. A write while armed leaves the stored step unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| armed | input | 1 | High: run the sequence; low: hold at step 0 and accept writes |
| sampleEn | input | 1 | Sample qualifier; the engine evaluates only when high |
| matchBits | input | NUM_UNITS | Comparator match vector |
| lastStep | input | STEP_W | Index of the final step (active steps minus one) |
| cfgWe | input | 1 | Step configuration write strobe |
| cfgStep | input | STEP_W | Step index being written |
| cfgTable | input | 2**NUM_UNITS | Truth table of the step condition |
| cfgNext | input | 1 | 1: must start on the next sample; 0: any later sample |
| cfgConsec | input | 1 | 1: hits must be back to back; 0: hits may be spread |
| cfgCount | input | CNT_W | Required occurrences (0 treated as 1) |
| trigger | output | 1 | One-cycle pulse when the final step completes |
| stepIdx | output | STEP_W | Step currently being searched |

## Verification
The same two-unit pattern is replayed under each pair of modes. A first-unit hit, a gap, then a second-unit hit separates any-time linking from next-sample linking. A hit, a false sample and another hit separates spread counts from back-to-back counts. The combination of next-sample linking with a back-to-back count is tried with a one-sample gap before the run, which must fail, and with no gap, which must pass. Samples where both bits are set, and samples that break a rule while matching step 0, show that one sample never serves two steps. Gated samples, writes made while armed, a single-step chain, a four-step mixed chain using AND, XOR and NOT tables, and a full sixteen-step chain cover the remaining boundaries.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

  typedef struct packed {
    logic cntInc;
    logic cntClr;
  } cnt_ctl_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;

endpackage

// File: rtl/trig_seq_datapath.sv
module trig_seq_datapath
  import trig_seq_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int MAX_STEPS = 16,
  parameter int CNT_W     = 8,
  localparam int TAB_W    = 1 << NUM_UNITS,
  localparam int STEP_W   = $clog2(MAX_STEPS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 armed,
  input  logic                 cfgWe,
  input  logic [STEP_W-1:0]    cfgStep,
  input  logic [TAB_W-1:0]     cfgTable,
  input  logic                 cfgNext,
  input  logic                 cfgConsec,
  input  logic [CNT_W-1:0]     cfgCount,
  input  logic [STEP_W-1:0]    stepIdx,
  input  logic [NUM_UNITS-1:0] matchBits,
  input  cnt_ctl_t             ctl,
  output logic                 condTrue,
  output logic                 countHit,
  output logic                 linkNext,
  output logic                 consecMode,
  output logic                 cntNonZero
);

  logic [TAB_W-1:0] tabMem    [MAX_STEPS];
  logic             nextMem   [MAX_STEPS];
  logic             consecMem [MAX_STEPS];
  logic [CNT_W-1:0] countMem  [MAX_STEPS];

  logic             wrEn;
  logic [TAB_W-1:0] tabSel;
  logic [CNT_W-1:0] limitSel;
  logic [CNT_W-1:0] needVal;
  logic [CNT_W:0]   cntPlus;
  logic [CNT_W-1:0] cntQ;

  assign wrEn = cfgWe && !armed;

  for (genvar g = 0; g < MAX_STEPS; g++) begin : gStep
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tabMem[g]    <= '0;
        nextMem[g]   <= 1'b0;
        consecMem[g] <= 1'b0;
        countMem[g]  <= '0;
      end else if (wrEn && cfgStep == STEP_W'(g)) begin
        tabMem[g]    <= cfgTable;
        nextMem[g]   <= cfgNext;
        consecMem[g] <= cfgConsec;
        countMem[g]  <= cfgCount;
      end
    end
  end

  always_comb begin
    tabSel     = tabMem[stepIdx];
    limitSel   = countMem[stepIdx];
    linkNext   = nextMem[stepIdx] && (stepIdx != '0);
    consecMode = consecMem[stepIdx];
    needVal    = (limitSel == '0) ? CNT_W'(1) : limitSel;
    condTrue   = tabSel[matchBits];
    cntPlus    = {1'b0, cntQ} + 1'b1;
    countHit   = cntPlus >= {1'b0, needVal};
    cntNonZero = cntQ != '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cntQ <= '0;
    else if (ctl.cntClr) cntQ <= '0;
    else if (ctl.cntInc) cntQ <= cntQ + 1'b1;
  end

  AST_CNT_BELOW_NEED: assert property (@(posedge clk) disable iff (!rstN)
    cntQ < needVal); // R6

  AST_CNT_CLEAR_DISARMED: assert property (@(posedge clk) disable iff (!rstN)
    !armed |=> cntQ == '0); // R1

endmodule

// File: rtl/trig_seq_control.sv
module trig_seq_control
  import trig_seq_pkg::*;
#(
  parameter int MAX_STEPS = 16,
  localparam int STEP_W   = $clog2(MAX_STEPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              armed,
  input  logic              sampleEn,
  input  logic [STEP_W-1:0] lastStep,
  input  logic              condTrue,
  input  logic              countHit,
  input  logic              linkNext,
  input  logic              consecMode,
  input  logic              cntNonZero,
  output cnt_ctl_t          ctl,
  output logic [STEP_W-1:0] stepIdx,
  output logic              trigger
);

  seq_state_e        stateQ;
  logic [STEP_W-1:0] stepQ;
  logic              firstQ;
  logic              trigQ;
  logic              evalNow;
  logic              advance;
  logic              broken;

  always_comb begin
    evalNow     = armed && (stateQ != SEQ_DONE) && sampleEn;
    advance     = evalNow && condTrue && countHit;
    broken      = evalNow && !condTrue &&
                  ((linkNext && firstQ) || (consecMode && cntNonZero));
    ctl.cntClr  = !armed || advance || broken;
    ctl.cntInc  = evalNow && condTrue && !countHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= SEQ_IDLE;
      stepQ  <= '0;
      firstQ <= 1'b0;
      trigQ  <= 1'b0;
    end else begin
      trigQ <= 1'b0;
      if (!armed) begin
        stateQ <= SEQ_IDLE;
        stepQ  <= '0;
        firstQ <= 1'b0;
      end else if (stateQ != SEQ_DONE) begin
        stateQ <= SEQ_RUN;
        if (evalNow) begin
          firstQ <= 1'b0;
          if (advance) begin
            if (stepQ == lastStep) begin
              trigQ  <= 1'b1;
              stateQ <= SEQ_DONE;
            end else begin
              stepQ  <= stepQ + 1'b1;
              firstQ <= 1'b1;
            end
          end else if (broken) begin
            stepQ <= '0;
          end
        end
      end
    end
  end

  assign stepIdx = stepQ;
  assign trigger = trigQ;

  AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    trigQ |=> !trigQ); // R10

  AST_DISARM_HOME: assert property (@(posedge clk) disable iff (!rstN)
    !armed |=> (stepQ == '0 && !trigQ)); // R1

  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !sampleEn) |=> ($stable(stepQ) && !trigQ)); // R2

  AST_STEP_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    armed |=> (stepQ == '0 || stepQ == $past(stepQ) ||
               stepQ == STEP_W'($past(stepQ) + 1'b1))); // R9

  AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (armed && stateQ == SEQ_DONE) |=> ($stable(stepQ) && !trigQ)); // R10

  AST_RUN_BREAK: assert property (@(posedge clk) disable iff (!rstN)
    (evalNow && !condTrue && consecMode && cntNonZero) |=> stepQ == '0); // R7

  AST_NEXT_BREAK: assert property (@(posedge clk) disable iff (!rstN)
    (evalNow && !condTrue && linkNext && firstQ) |=> stepQ == '0); // R5

endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_seq_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int MAX_STEPS = 16,
  parameter int CNT_W     = 8,
  localparam int TAB_W    = 1 << NUM_UNITS,
  localparam int STEP_W   = $clog2(MAX_STEPS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 armed,
  input  logic                 sampleEn,
  input  logic [NUM_UNITS-1:0] matchBits,
  input  logic [STEP_W-1:0]    lastStep,
  input  logic                 cfgWe,
  input  logic [STEP_W-1:0]    cfgStep,
  input  logic [TAB_W-1:0]     cfgTable,
  input  logic                 cfgNext,
  input  logic                 cfgConsec,
  input  logic [CNT_W-1:0]     cfgCount,
  output logic                 trigger,
  output logic [STEP_W-1:0]    stepIdx
);

  cnt_ctl_t ctl;
  logic     condTrue, countHit, linkNext, consecMode, cntNonZero;

  trig_seq_datapath #(
    .NUM_UNITS(NUM_UNITS), .MAX_STEPS(MAX_STEPS), .CNT_W(CNT_W)
  ) uData (
    .clk(clk), .rstN(rstN), .armed(armed), .cfgWe(cfgWe),
    .cfgStep(cfgStep), .cfgTable(cfgTable), .cfgNext(cfgNext),
    .cfgConsec(cfgConsec), .cfgCount(cfgCount), .stepIdx(stepIdx),
    .matchBits(matchBits), .ctl(ctl), .condTrue(condTrue),
    .countHit(countHit), .linkNext(linkNext), .consecMode(consecMode),
    .cntNonZero(cntNonZero)
  );

  trig_seq_control #(
    .MAX_STEPS(MAX_STEPS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .armed(armed), .sampleEn(sampleEn),
    .lastStep(lastStep), .condTrue(condTrue), .countHit(countHit),
    .linkNext(linkNext), .consecMode(consecMode), .cntNonZero(cntNonZero),
    .ctl(ctl), .stepIdx(stepIdx), .trigger(trigger)
  );

endmodule

// File: tb/tb_trig_seq.sv
`timescale 1ns/1ps
module tb_trig_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        armed = 1'b0;
  logic        sampleEn = 1'b0;
  logic [3:0]  matchBits = '0;
  logic [3:0]  lastStep = '0;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgStep = '0;
  logic [15:0] cfgTable = '0;
  logic        cfgNext = 1'b0;
  logic        cfgConsec = 1'b0;
  logic [7:0]  cfgCount = '0;
  logic        trigger;
  logic [3:0]  stepIdx;

  int checks = 0;
  int errors = 0;
  int trigSeen = 0;
  bit finished = 0;
  string curTag = "R1";

  // behavioural reference state
  int mTab [16];
  int mNext [16];
  int mCons [16];
  int mCount [16];
  int mStep = 0, mCnt = 0, mFirst = 0, mState = 0, mTrig = 0;

  trig_seq dut (
    .clk(clk), .rstN(rstN), .armed(armed), .sampleEn(sampleEn),
    .matchBits(matchBits), .lastStep(lastStep), .cfgWe(cfgWe),
    .cfgStep(cfgStep), .cfgTable(cfgTable), .cfgNext(cfgNext),
    .cfgConsec(cfgConsec), .cfgCount(cfgCount), .trigger(trigger),
    .stepIdx(stepIdx)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) begin
      mStep = 0; mCnt = 0; mFirst = 0; mState = 0; mTrig = 0;
      for (int i = 0; i < 16; i++) begin
        mTab[i] = 0; mNext[i] = 0; mCons[i] = 0; mCount[i] = 0;
      end
    end else begin
      mTrig = 0;
      if (!armed) begin
        if (cfgWe) begin
          mTab[cfgStep] = cfgTable; mNext[cfgStep] = cfgNext;
          mCons[cfgStep] = cfgConsec; mCount[cfgStep] = cfgCount;
        end
        mStep = 0; mCnt = 0; mFirst = 0; mState = 0;
      end else if (mState != 2 && sampleEn) begin
        int need;
        int hit;
        hit = (mTab[mStep] >> matchBits) & 1;
        need = (mCount[mStep] == 0) ? 1 : mCount[mStep];
        if (hit != 0) begin
          if (mCnt + 1 >= need) begin
            mCnt = 0;
            if (mStep == int'(lastStep)) begin mTrig = 1; mState = 2; mFirst = 0; end
            else begin mStep = mStep + 1; mFirst = 1; end
          end else begin
            mCnt = mCnt + 1; mFirst = 0;
          end
        end else begin
          if ((mStep != 0 && mNext[mStep] != 0 && mFirst != 0) ||
              (mCons[mStep] != 0 && mCnt > 0)) begin
            mStep = 0; mCnt = 0;
          end
          mFirst = 0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", curTag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    if (trigger) trigSeen++;
    check(int'(stepIdx) == mStep, "stepIdx", int'(stepIdx), mStep);
    check(int'(trigger) == mTrig, "trigger", int'(trigger), mTrig);
  endtask

  task automatic samp(input logic [3:0] m);
    sampleEn = 1'b1; matchBits = m;
    tick();
    sampleEn = 1'b0; matchBits = '0;
  endtask

  task automatic prog(input int s, input logic [15:0] t, input bit nx,
                      input bit cs, input int n);
    cfgWe = 1'b1; cfgStep = 4'(s); cfgTable = t; cfgNext = nx;
    cfgConsec = cs; cfgCount = 8'(n);
    tick();
    cfgWe = 1'b0;
  endtask

  task automatic disarm();
    armed = 1'b0;
    tick();
  endtask

  task automatic arm(input int last);
    lastStep = 4'(last);
    armed = 1'b1;
    trigSeen = 0;
    tick();
  endtask

  task automatic expectTrig(input int n);
    check(trigSeen == n, "trigger count", trigSeen, n);
  endtask

  // tables: bit0 set = AAAA, bit1 set = CCCC, AND = 8888, XOR = 6666, NOT bit1 = 3333
  initial begin
    repeat (3) @(posedge clk);
    #1;
    curTag = "R1";
    check(stepIdx == 4'd0, "reset stepIdx", int'(stepIdx), 0);
    check(trigger == 1'b0, "reset trigger", int'(trigger), 0);
    rstN = 1'b1;
    tick();

    // R3 R4: any-time link
    curTag = "R4";
    prog(0, 16'hAAAA, 0, 0, 1);
    prog(1, 16'hCCCC, 0, 0, 1);
    arm(1);
    samp(4'd1); samp(4'd4); samp(4'd2);
    expectTrig(1);
    curTag = "R3";
    check(stepIdx == 4'd1, "stepIdx after chain", int'(stepIdx), 1);

    // R5: next-sample link
    curTag = "R5";
    disarm();
    prog(1, 16'hCCCC, 1, 0, 1);
    arm(1);
    samp(4'd1); samp(4'd0);
    check(stepIdx == 4'd0, "gap resets", int'(stepIdx), 0);
    samp(4'd2);
    expectTrig(0);
    samp(4'd1); samp(4'd2);
    expectTrig(1);

    // R6: spread count
    curTag = "R6";
    disarm();
    prog(1, 16'hCCCC, 0, 0, 2);
    arm(1);
    samp(4'd1); samp(4'd2); samp(4'd0); samp(4'd2);
    expectTrig(1);

    // R7: back-to-back count
    curTag = "R7";
    disarm();
    prog(1, 16'hCCCC, 0, 1, 2);
    arm(1);
    samp(4'd1); samp(4'd2); samp(4'd0);
    check(stepIdx == 4'd0, "run break resets", int'(stepIdx), 0);
    samp(4'd2);
    expectTrig(0);
    samp(4'd1); samp(4'd2); samp(4'd2);
    expectTrig(1);

    // R8: next link with back-to-back count
    curTag = "R8";
    disarm();
    prog(1, 16'hCCCC, 1, 1, 2);
    arm(1);
    samp(4'd1); samp(4'd0); samp(4'd2); samp(4'd2);
    expectTrig(0);
    samp(4'd1); samp(4'd2); samp(4'd2);
    expectTrig(1);

    // R2: gated samples
    curTag = "R2";
    disarm();
    prog(1, 16'hCCCC, 0, 0, 1);
    arm(1);
    samp(4'd1);
    matchBits = 4'd2;
    repeat (3) tick();
    matchBits = '0;
    expectTrig(0);
    check(stepIdx == 4'd1, "held step", int'(stepIdx), 1);
    samp(4'd2);
    expectTrig(1);

    // R9: one sample one step; breaking sample not reused
    curTag = "R9";
    disarm();
    arm(1);
    samp(4'd3);
    expectTrig(0);
    check(stepIdx == 4'd1, "single advance", int'(stepIdx), 1);
    samp(4'd3);
    expectTrig(1);
    disarm();
    prog(1, 16'hCCCC, 1, 0, 1);
    arm(1);
    samp(4'd1); samp(4'd1); samp(4'd2);
    expectTrig(0);
    samp(4'd1); samp(4'd2);
    expectTrig(1);

    // R10: done state ignores samples
    curTag = "R10";
    samp(4'd1); samp(4'd2); samp(4'd1); samp(4'd2);
    expectTrig(1);
    check(stepIdx == 4'd1, "done holds", int'(stepIdx), 1);
    disarm();
    arm(1);
    samp(4'd1); samp(4'd2);
    expectTrig(1);

    // R11: one step with count 0, a mixed four-step chain, then sixteen steps
    curTag = "R11";
    disarm();
    prog(0, 16'hAAAA, 0, 0, 0);
    arm(0);
    samp(4'd1);
    expectTrig(1);
    disarm();
    prog(0, 16'h8888, 0, 0, 1);
    prog(1, 16'h6666, 1, 0, 1);
    prog(2, 16'hAAAA, 0, 0, 3);
    prog(3, 16'h3333, 0, 0, 1);
    arm(3);
    samp(4'd3); samp(4'd1); samp(4'd1); samp(4'd0); samp(4'd1);
    expectTrig(0);
    samp(4'd1); samp(4'd0);
    expectTrig(1);
    disarm();
    for (int s = 0; s < 16; s++) prog(s, 16'hAAAA, 0, 0, 1);
    arm(15);
    for (int s = 0; s < 15; s++) samp(4'd1);
    expectTrig(0);
    check(stepIdx == 4'd15, "last step reached", int'(stepIdx), 15);
    samp(4'd1);
    expectTrig(1);

    // R12: writes while armed ignored
    curTag = "R12";
    disarm();
    prog(0, 16'hAAAA, 0, 0, 1);
    prog(1, 16'hCCCC, 0, 0, 1);
    arm(1);
    prog(1, 16'hAAAA, 0, 0, 1);
    samp(4'd1); samp(4'd1);
    expectTrig(0);
    samp(4'd2);
    expectTrig(1);

    curTag = "R1";
    disarm();
    check(stepIdx == 4'd0, "disarm home", int'(stepIdx), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL %s watchdog: actual 0 expected 1", curTag);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule